// File: doc/BRIEF.md
# Segmented Row Broadcast Network

This block is a single row of cells that share a broadcast medium carrying an 8-bit payload. Each cell gets a two-bit role every cycle: relay, source, barrier or portal. Contiguous runs of non-barrier cells form segments. The two ends of the row bound a segment in the same way as a barrier cell. A source cell puts its value on its own segment. The value reaches every cell of that segment within the same cycle. It never crosses a barrier.

The source's mode bit picks one of two delivery styles. In flood mode every non-barrier cell of the segment takes the value. In pinpoint mode only the portal cells of the segment take it. All deliveries are captured on the next clock edge. A delivery raises a one-cycle valid flag on each receiving cell. If a segment holds more than one source, the source with the lowest index drives the segment, and every cell of that segment reports a clash flag.

Top module: `seg_bcast_row`

## Requirements
- R1: In the first cycle after synchronous reset, every `rx_valid` and `rx_conflict` bit is 0 and every `rx_data` lane is 0.
- R2: When the winning source of a segment has mode 0 (flood), every non-barrier cell of that segment takes the source's 8-bit value. This includes the source and any portal cells. `rx_valid` is high one clock after the inputs are presented.
- R3: A segment spans the maximal run of cells whose role is not 2 (barrier). Index 0 and index N-1 bound it like barriers. A cell whose segment holds no source (role 1) gets no valid.
- R4: A cell with role 2 never receives, never reports a clash and never acts as a source, whatever its mode or data.
- R5: When the winning source has mode 1 (pinpoint), only cells of that segment with role 3 (portal) take the value. All other cells of the segment stay not valid.
- R6: When a segment holds several sources, the value and mode of the source with the lowest index decide the delivery for that whole segment.
- R7: `rx_conflict` is high, one clock later, on every non-barrier cell of a segment holding two or more sources, and low elsewhere.
- R8: When a cell is not valid, its `rx_data` lane keeps the last value it took.
- R9: Segments separated by a barrier deliver their own values independently in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cell_role | input | 2*N_CELLS | Role per cell, lane i at bits [2i+1:2i]: 0 relay, 1 source, 2 barrier, 3 portal |
| cell_mode | input | N_CELLS | Delivery mode of a source: 0 flood, 1 pinpoint |
| cell_data | input | 8*N_CELLS | Payload offered by each cell, lane i at bits [8i+7:8i] |
| rx_data | output | 8*N_CELLS | Registered value taken by each cell |
| rx_valid | output | N_CELLS | One-cycle flag per cell: a value was taken |
| rx_conflict | output | N_CELLS | Cell lies in a segment that held two or more sources |

## Verification
The bench sweeps every role assignment of a six-cell row under three mode patterns. This exercises segments that touch either row end, barrier cells next to each other, and rows made only of barriers. A design that let a value leak past a barrier or wrap at the row ends would give valid to cells in other segments. A design that picked the highest-index source, or mixed two sources, would give the wrong lane value and no clash flag. Pinpoint mode is checked against relays and the source itself, which must stay silent. Hold behaviour is checked by comparing each idle lane with the value it last took. A design that cleared or refreshed idle lanes would fail that check.

// File: rtl/seg_bcast_pkg.sv
package seg_bcast_pkg;
  typedef enum logic [1:0] {
    ROLE_RELAY  = 2'd0,
    ROLE_SRC    = 2'd1,
    ROLE_BLOCK  = 2'd2,
    ROLE_PORTAL = 2'd3
  } role_e;

  localparam logic MODE_FLOOD = 1'b0;
  localparam logic MODE_PIN   = 1'b1;
endpackage

// File: rtl/seg_bcast_lscan.sv
// Left-to-right pass: first source seen since the segment start.
module seg_bcast_lscan
  import seg_bcast_pkg::*;
#(
  parameter int N_CELLS = 8,
  parameter int DATA_W  = 8
) (
  input  logic [N_CELLS-1:0][1:0]        role,
  input  logic [N_CELLS-1:0]             mode,
  input  logic [N_CELLS-1:0][DATA_W-1:0] data,
  output logic [N_CELLS-1:0]             l_hit,
  output logic [N_CELLS-1:0]             l_multi,
  output logic [N_CELLS-1:0]             l_mode,
  output logic [N_CELLS-1:0][DATA_W-1:0] l_data
);
  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    logic              p_hit, p_multi, p_mode;
    logic [DATA_W-1:0] p_data;
    logic              is_blk, is_src;

    if (i == 0) begin : g_edge
      assign p_hit   = 1'b0;
      assign p_multi = 1'b0;
      assign p_mode  = 1'b0;
      assign p_data  = '0;
    end else begin : g_chain
      assign p_hit   = l_hit[i-1];
      assign p_multi = l_multi[i-1];
      assign p_mode  = l_mode[i-1];
      assign p_data  = l_data[i-1];
    end

    assign is_blk     = (role[i] == ROLE_BLOCK);
    assign is_src     = (role[i] == ROLE_SRC);
    assign l_hit[i]   = !is_blk && (p_hit || is_src);
    assign l_multi[i] = !is_blk && (p_multi || (p_hit && is_src));
    assign l_mode[i]  = p_hit ? p_mode : mode[i];
    assign l_data[i]  = p_hit ? p_data : data[i];
  end
endmodule

// File: rtl/seg_bcast_rscan.sv
// Right-to-left pass: spreads each segment's final result to all its cells.
module seg_bcast_rscan
  import seg_bcast_pkg::*;
#(
  parameter int N_CELLS = 8,
  parameter int DATA_W  = 8
) (
  input  logic [N_CELLS-1:0][1:0]        role,
  input  logic [N_CELLS-1:0]             l_hit,
  input  logic [N_CELLS-1:0]             l_multi,
  input  logic [N_CELLS-1:0]             l_mode,
  input  logic [N_CELLS-1:0][DATA_W-1:0] l_data,
  output logic [N_CELLS-1:0]             s_hit,
  output logic [N_CELLS-1:0]             s_multi,
  output logic [N_CELLS-1:0]             s_mode,
  output logic [N_CELLS-1:0][DATA_W-1:0] s_data
);
  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    logic is_blk;
    assign is_blk = (role[i] == ROLE_BLOCK);

    if (i == N_CELLS - 1) begin : g_last
      assign s_hit[i]   = !is_blk && l_hit[i];
      assign s_multi[i] = !is_blk && l_multi[i];
      assign s_mode[i]  = l_mode[i];
      assign s_data[i]  = l_data[i];
    end else begin : g_mid
      logic seg_end;
      assign seg_end    = (role[i+1] == ROLE_BLOCK);
      assign s_hit[i]   = !is_blk && (seg_end ? l_hit[i]   : s_hit[i+1]);
      assign s_multi[i] = !is_blk && (seg_end ? l_multi[i] : s_multi[i+1]);
      assign s_mode[i]  = seg_end ? l_mode[i] : s_mode[i+1];
      assign s_data[i]  = seg_end ? l_data[i] : s_data[i+1];
    end
  end
endmodule

// File: rtl/seg_bcast_deliver.sv
// Per-cell capture stage: decides who takes the value and registers it.
module seg_bcast_deliver
  import seg_bcast_pkg::*;
#(
  parameter int N_CELLS = 8,
  parameter int DATA_W  = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [N_CELLS-1:0][1:0]        role,
  input  logic [N_CELLS-1:0]             s_hit,
  input  logic [N_CELLS-1:0]             s_multi,
  input  logic [N_CELLS-1:0]             s_mode,
  input  logic [N_CELLS-1:0][DATA_W-1:0] s_data,
  output logic [N_CELLS-1:0][DATA_W-1:0] q_data,
  output logic [N_CELLS-1:0]             q_valid,
  output logic [N_CELLS-1:0]             q_conflict
);
  logic [N_CELLS-1:0] take;

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    assign take[i] = s_hit[i] &&
                     ((s_mode[i] == MODE_FLOOD) || (role[i] == ROLE_PORTAL));

    always_ff @(posedge clk) begin
      if (rst) begin
        q_data[i]     <= '0;
        q_valid[i]    <= 1'b0;
        q_conflict[i] <= 1'b0;
      end else begin
        q_valid[i]    <= take[i];
        q_conflict[i] <= s_multi[i];
        if (take[i]) q_data[i] <= s_data[i];
      end
    end
  end
endmodule

// File: rtl/seg_bcast_row.sv
module seg_bcast_row
  import seg_bcast_pkg::*;
#(
  parameter int N_CELLS = 8,
  parameter int DATA_W  = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [2*N_CELLS-1:0]        cell_role,
  input  logic [N_CELLS-1:0]          cell_mode,
  input  logic [DATA_W*N_CELLS-1:0]   cell_data,
  output logic [DATA_W*N_CELLS-1:0]   rx_data,
  output logic [N_CELLS-1:0]          rx_valid,
  output logic [N_CELLS-1:0]          rx_conflict
);
  logic [N_CELLS-1:0][1:0]        role;
  logic [N_CELLS-1:0][DATA_W-1:0] data;
  logic [N_CELLS-1:0][DATA_W-1:0] q_data;

  logic [N_CELLS-1:0]             l_hit, l_multi, l_mode;
  logic [N_CELLS-1:0][DATA_W-1:0] l_data;
  logic [N_CELLS-1:0]             s_hit, s_multi, s_mode;
  logic [N_CELLS-1:0][DATA_W-1:0] s_data;

  assign role    = cell_role;
  assign data    = cell_data;
  assign rx_data = q_data;

  seg_bcast_lscan #(.N_CELLS(N_CELLS), .DATA_W(DATA_W)) u_lscan (
    .role(role), .mode(cell_mode), .data(data),
    .l_hit(l_hit), .l_multi(l_multi), .l_mode(l_mode), .l_data(l_data)
  );

  seg_bcast_rscan #(.N_CELLS(N_CELLS), .DATA_W(DATA_W)) u_rscan (
    .role(role),
    .l_hit(l_hit), .l_multi(l_multi), .l_mode(l_mode), .l_data(l_data),
    .s_hit(s_hit), .s_multi(s_multi), .s_mode(s_mode), .s_data(s_data)
  );

  seg_bcast_deliver #(.N_CELLS(N_CELLS), .DATA_W(DATA_W)) u_deliver (
    .clk(clk), .rst(rst), .role(role),
    .s_hit(s_hit), .s_multi(s_multi), .s_mode(s_mode), .s_data(s_data),
    .q_data(q_data), .q_valid(rx_valid), .q_conflict(rx_conflict)
  );
endmodule

// File: rtl/seg_bcast_chk.sv
module seg_bcast_chk
  import seg_bcast_pkg::*;
#(
  parameter int N_CELLS = 8,
  parameter int DATA_W  = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic [2*N_CELLS-1:0]      cell_role,
  input logic [N_CELLS-1:0]        cell_mode,
  input logic [DATA_W*N_CELLS-1:0] rx_data,
  input logic [N_CELLS-1:0]        rx_valid,
  input logic [N_CELLS-1:0]        rx_conflict
);
  logic [N_CELLS-1:0] src_vec, flood_vec;

  for (genvar i = 0; i < N_CELLS; i++) begin : g_vec
    assign src_vec[i]   = (cell_role[2*i +: 2] == ROLE_SRC);
    assign flood_vec[i] = src_vec[i] && (cell_mode[i] == MODE_FLOOD);
  end

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rx_valid == '0 && rx_conflict == '0 && rx_data == '0));

  p_idle_row_r3: assert property (@(posedge clk) disable iff (rst)
    (src_vec == '0) |=> (rx_valid == '0));

  p_conflict_needs_two_r7: assert property (@(posedge clk) disable iff (rst)
    ($countones(src_vec) < 2) |=> (rx_conflict == '0));

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    p_block_quiet_r4: assert property (@(posedge clk) disable iff (rst)
      (cell_role[2*i +: 2] == ROLE_BLOCK) |=> (!rx_valid[i] && !rx_conflict[i]));

    p_pin_only_portal_r5: assert property (@(posedge clk) disable iff (rst)
      ((cell_role[2*i +: 2] != ROLE_PORTAL) && (flood_vec == '0)) |=> !rx_valid[i]);

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !rx_valid[i] |-> $stable(rx_data[DATA_W*i +: DATA_W]));

    if (i < N_CELLS - 1) begin : g_pair
      p_segment_agree_r2: assert property (@(posedge clk) disable iff (rst)
        ((cell_role[2*i +: 2] != ROLE_BLOCK) && (cell_role[2*(i+1) +: 2] != ROLE_BLOCK))
        |=> (!(rx_valid[i] && rx_valid[i+1]) ||
             (rx_data[DATA_W*i +: DATA_W] == rx_data[DATA_W*(i+1) +: DATA_W])));
    end
  end
endmodule

bind seg_bcast_row seg_bcast_chk #(.N_CELLS(N_CELLS), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .cell_role(cell_role), .cell_mode(cell_mode),
  .rx_data(rx_data), .rx_valid(rx_valid), .rx_conflict(rx_conflict)
);

// File: tb/tb_seg_bcast_row.sv
module tb_seg_bcast_row;
  localparam int N  = 6;
  localparam int DW = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [2*N-1:0]    cell_role = '0;
  logic [N-1:0]      cell_mode = '0;
  logic [DW*N-1:0]   cell_data = '0;
  logic [DW*N-1:0]   rx_data;
  logic [N-1:0]      rx_valid;
  logic [N-1:0]      rx_conflict;

  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit done = 1'b0;

  int         rl [N];
  int         md [N];
  logic [7:0] dv [N];
  logic [7:0] held [N];

  always #2.5 clk = ~clk;

  seg_bcast_row #(.N_CELLS(N), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .cell_role(cell_role), .cell_mode(cell_mode),
    .cell_data(cell_data), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_conflict(rx_conflict)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      bad++;
      total++;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic apply();
    for (int i = 0; i < N; i++) begin
      cell_role[2*i +: 2]  = rl[i][1:0];
      cell_mode[i]         = md[i][0];
      cell_data[DW*i +: DW] = dv[i];
    end
  endtask

  // Independent reference: locate segment bounds, count sources, pick lowest.
  task automatic verify();
    for (int i = 0; i < N; i++) begin
      int lo, hi, cnt, win;
      bit ev, ec;
      logic [7:0] ed;
      ev = 0; ec = 0;
      if (rl[i] != 2) begin
        lo = i; hi = i; cnt = 0; win = -1;
        while (lo > 0 && rl[lo-1] != 2) lo--;
        while (hi < N-1 && rl[hi+1] != 2) hi++;
        for (int k = hi; k >= lo; k--)
          if (rl[k] == 1) begin cnt++; win = k; end
        ec = (cnt >= 2);
        if (cnt > 0) ev = (md[win] == 0) || (rl[i] == 3);
        if (ev) held[i] = dv[win];
        check(rx_valid[i] == ev,
              (cnt == 0) ? "R3 valid" : ((md[win] == 1) ? "R5 valid" : "R2 valid"),
              rx_valid[i], ev);
        check(rx_conflict[i] == ec, "R7 conflict", rx_conflict[i], ec);
      end else begin
        check(rx_valid[i] == 0 && rx_conflict[i] == 0, "R4 barrier",
              {rx_valid[i], rx_conflict[i]}, 0);
      end
      ed = held[i];
      check(rx_data[DW*i +: DW] == ed, ev ? (ec ? "R6 data" : "R2 data") : "R8 hold",
            rx_data[DW*i +: DW], ed);
    end
  endtask

  task automatic step();
    apply();
    @(posedge clk);
    #1;
    verify();
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      rl[i] = 0; md[i] = 0; dv[i] = 8'h00; held[i] = 8'h00;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    // R1: reset state
    check(rx_valid == '0, "R1 valid", rx_valid, 0);
    check(rx_conflict == '0, "R1 conflict", rx_conflict, 0);
    check(rx_data == '0, "R1 data", rx_data[31:0], 0);
    @(negedge clk);

    // R9: two segments with their own values in one cycle
    rl = '{1, 0, 2, 0, 1, 3};
    md = '{0, 0, 0, 0, 0, 0};
    dv = '{8'hA1, 8'h00, 8'h00, 8'h00, 8'h5C, 8'h00};
    apply();
    @(posedge clk);
    #1;
    check(rx_data[DW*1 +: DW] == 8'hA1, "R9 left seg", rx_data[DW*1 +: DW], 8'hA1);
    check(rx_data[DW*5 +: DW] == 8'h5C, "R9 right seg", rx_data[DW*5 +: DW], 8'h5C);
    held = '{8'hA1, 8'hA1, 8'h00, 8'h5C, 8'h5C, 8'h5C};
    @(negedge clk);

    // Sweep: all role patterns under three mode patterns
    for (int v = 0; v < 3; v++) begin
      for (int code = 0; code < (1 << (2*N)); code++) begin
        for (int i = 0; i < N; i++) begin
          rl[i] = (code >> (2*i)) & 3;
          md[i] = (v == 0) ? 0 : ((v == 1) ? 1 : ((code >> i) ^ i) & 1);
          dv[i] = 8'((code * 7 + i * 31 + v * 101) & 8'hFF);
        end
        step();
      end
    end

    // R8: row with no source holds every lane
    for (int i = 0; i < N; i++) begin rl[i] = 0; dv[i] = 8'hEE; end
    step();

    // R4: barrier with source-like data does nothing
    for (int i = 0; i < N; i++) begin rl[i] = 2; md[i] = 0; dv[i] = 8'h77; end
    step();

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule